// File: doc/BRIEF.md
# Atomic Halfword XOR Read-Modify-Write Unit

This unit carries out one indivisible exclusive-OR update of a 16-bit halfword in memory. The core hands it a decoded request: the value of the selected base register, the current stack pointer, the base register index, a 16-bit operand, the destination register index, and two ordering flags (acquire and release). The unit resolves the effective address and screens the request for faults. It then locks a word-wide memory port and reads the word that holds the halfword. It writes back the old halfword XOR the operand through byte enables, and it returns the old halfword, zero-extended, on a register-write port.

A base index of 31 selects the stack pointer, and that pointer must be 16-byte aligned. A destination index of 31 is the discard register. It suppresses the register write and also removes the acquire ordering. When the acquire ordering is in force, completion is withheld until memory acknowledges the write. Requests are accepted only while the unit is idle. The reset input is asynchronous and active low, and its release must be synchronous to the clock.

Top module: `amo_xorh_unit`

## Requirements
- R1: After a fault-free operation, the addressed halfword in memory holds its old value XOR `req_operand`, and the other halfword of that word is unchanged.
- R2: When the destination index is not 31 and no fault occurs, the completing cycle drives `rf_we`=1, `rf_idx` = the destination index, and `rf_data` = the old halfword in bits 15:0 with bits 31:16 zero.
- R3: A destination index of 31 gives `rf_we`=0, while the memory update and the `done` pulse still take place.
- R4: During memory accesses, `mem_acq` is 1 exactly when the acquire flag is 1 and the destination index is not 31. `mem_rel` equals the release flag. `mem_tagchk` is 1 exactly when the base index is not 31.
- R5: A base index of 31 takes the address from `req_sp_val`. If bits 3:0 of that pointer are not zero, the operation ends with `flt_stack`=1, makes no memory access and does no register write.
- R6: With `atomics_en`=0, the operation ends with `flt_illegal`=1, makes no memory access and does no register write. This fault takes priority over the stack and alignment faults.
- R7: An effective address with bit 0 set ends with `flt_align`=1, makes no memory access and does no register write.
- R8: `mem_lock` is high from the first read request until the cycle in which `mem_wack` is seen, and `req_ready` is low for that whole span.
- R9: `done` is a single-cycle pulse. For a faulting request it comes two cycles after acceptance. Without acquire it comes one cycle after the write request. With acquire it comes one cycle after `mem_wack`.
- R10: Effective address bit 1 selects the halfword. When it is 0, the old value is read from `mem_rdata[15:0]` and `mem_be`=4'b0011. When it is 1, the old value is read from `mem_rdata[31:16]` and `mem_be`=4'b1100. `mem_addr` carries address bits 63:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| atomics_en | input | 1 | Atomic-operation extension present; 0 makes the request illegal |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_base_idx | input | 5 | Base register index (31 = stack pointer) |
| req_base_val | input | 64 | Value of the indexed base register |
| req_sp_val | input | 64 | Current stack pointer |
| req_operand | input | 16 | Low 16 bits of the source register |
| req_dst_idx | input | 5 | Destination register index (31 = discard) |
| req_acquire | input | 1 | Acquire flag |
| req_release | input | 1 | Release flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Port held exclusively for this operation |
| mem_addr | output | 62 | Word address |
| mem_wdata | output | 32 | Write data (new halfword in both halves) |
| mem_be | output | 4 | Byte enables for the write |
| mem_acq | output | 1 | Acquire attribute of the access |
| mem_rel | output | 1 | Release attribute of the access |
| mem_tagchk | output | 1 | Tag check requested for the access |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| mem_wack | input | 1 | Write acknowledge |
| done | output | 1 | Operation complete (one cycle) |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 5 | Register write index |
| rf_data | output | 32 | Register write data |
| flt_illegal | output | 1 | Illegal-operation fault, with done |
| flt_stack | output | 1 | Stack pointer alignment fault, with done |
| flt_align | output | 1 | Halfword alignment fault, with done |

## Verification
Some properties are checked by assertions on every cycle. Every memory request falls inside the lock window, and the unit is never ready while locked. `done` never lasts two cycles. A register write never targets index 31. A fault flag always comes with `done` and never with a register write. An acquire completion always follows a write acknowledge.

The bench scenarios cover the rest:
- the XOR result in the chosen halfword
- zero extension of the returned value
- which address source and attributes reach the port
- fault priority
- the exact completion cycle under different read and acknowledge latencies

The bench compares these against its own model of memory and timing.

// File: rtl/amox_pkg.sv
package amox_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FAULT = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WACK  = 3'd4
  } amox_state_e;

  typedef struct packed {
    logic acq;
    logic rel;
    logic tagchk;
  } amox_attr_t;

  typedef struct packed {
    logic illegal;
    logic stack;
    logic align;
  } amox_flt_t;

endpackage

// File: rtl/amox_decode.sv
module amox_decode
  import amox_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int IDX_W        = 5,
  parameter int SP_ALIGN_LG2 = 4
) (
  input  logic              feat_en,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic              acq_flag,
  input  logic              rel_flag,
  output logic [ADDR_W-1:0] eff_addr,
  output amox_attr_t        attr,
  output amox_flt_t         flt
);

  localparam logic [IDX_W-1:0] ZR_IDX = '1;

  logic use_sp;

  always_comb begin
    use_sp   = (base_idx == ZR_IDX);
    eff_addr = use_sp ? sp_val : base_val;
    // fault priority: illegal, then stack alignment, then halfword alignment
    flt = '0;
    if (!feat_en)
      flt.illegal = 1'b1;
    else if (use_sp && (sp_val[SP_ALIGN_LG2-1:0] != '0))
      flt.stack = 1'b1;
    else if (eff_addr[0])
      flt.align = 1'b1;
    attr.acq    = acq_flag && (dst_idx != ZR_IDX);
    attr.rel    = rel_flag;
    attr.tagchk = !use_sp;
  end

endmodule

// File: rtl/amox_datapath.sv
module amox_datapath #(
  parameter int MEM_DW = 32,
  parameter int HSEL_W = $clog2(MEM_DW / 16)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic [HSEL_W-1:0]   hsel,
  input  logic [MEM_DW-1:0]   rdata,
  input  logic [15:0]         operand,
  output logic [15:0]         old_hw,
  output logic [MEM_DW-1:0]   wdata,
  output logic [MEM_DW/8-1:0] be
);

  localparam int NHW = MEM_DW / 16;

  logic [15:0] rd_hw;
  logic [15:0] old_q;
  logic [15:0] old_d;
  logic [15:0] new_hw;

  always_comb begin
    rd_hw  = rdata[{hsel, 4'b0000} +: 16];
    old_d  = cap_en ? rd_hw : old_q;
    new_hw = old_q ^ operand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= '0;
    else        old_q <= old_d;
  end

  for (genvar g = 0; g < NHW; g++) begin : g_lane
    assign wdata[g*16 +: 16] = new_hw;
    assign be[g*2 +: 2]      = {2{hsel == HSEL_W'(g)}};
  end

  assign old_hw = old_q;

endmodule

// File: rtl/amox_fsm.sv
module amox_fsm
  import amox_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        req_flt,
  input  logic        acq,
  input  logic        rvalid,
  input  logic        wack,
  output amox_state_e state,
  output logic        fin,
  output logic        cap_en
);

  amox_state_e nxt;

  always_comb begin
    nxt    = state;
    fin    = 1'b0;
    cap_en = 1'b0;
    unique case (state)
      ST_IDLE:  if (accept) nxt = req_flt ? ST_FAULT : ST_READ;
      ST_FAULT: begin
        fin = 1'b1;
        nxt = ST_IDLE;
      end
      ST_READ:  if (rvalid) begin
        cap_en = 1'b1;
        nxt    = ST_WRITE;
      end
      ST_WRITE: begin
        fin = !acq;
        nxt = ST_WACK;
      end
      ST_WACK:  if (wack) begin
        fin = acq;
        nxt = ST_IDLE;
      end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/amo_xorh_unit.sv
module amo_xorh_unit
  import amox_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int IDX_W        = 5,
  parameter int MEM_DW       = 32,
  parameter int RF_W         = 32,
  parameter int SP_ALIGN_LG2 = 4,
  parameter int BYTE_LG2     = $clog2(MEM_DW / 8),
  parameter int HSEL_W       = $clog2(MEM_DW / 16)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   atomics_en,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX_W-1:0]       req_base_idx,
  input  logic [ADDR_W-1:0]      req_base_val,
  input  logic [ADDR_W-1:0]      req_sp_val,
  input  logic [15:0]            req_operand,
  input  logic [IDX_W-1:0]       req_dst_idx,
  input  logic                   req_acquire,
  input  logic                   req_release,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic                   mem_lock,
  output logic [ADDR_W-BYTE_LG2-1:0] mem_addr,
  output logic [MEM_DW-1:0]      mem_wdata,
  output logic [MEM_DW/8-1:0]    mem_be,
  output logic                   mem_acq,
  output logic                   mem_rel,
  output logic                   mem_tagchk,
  input  logic                   mem_rvalid,
  input  logic [MEM_DW-1:0]      mem_rdata,
  input  logic                   mem_wack,
  output logic                   done,
  output logic                   rf_we,
  output logic [IDX_W-1:0]       rf_idx,
  output logic [RF_W-1:0]        rf_data,
  output logic                   flt_illegal,
  output logic                   flt_stack,
  output logic                   flt_align
);

  localparam logic [IDX_W-1:0] ZR_IDX = '1;

  logic [ADDR_W-1:0] dec_addr;
  amox_attr_t        dec_attr;
  amox_flt_t         dec_flt;
  amox_state_e       state;
  logic              fin;
  logic              cap_en;
  logic              accept;
  logic [15:0]       old_hw;

  logic [ADDR_W-1:1] addr_q;
  logic [15:0]       opnd_q;
  logic [IDX_W-1:0]  dst_q;
  amox_attr_t        attr_q;
  amox_flt_t         flt_q;
  logic              done_q;
  logic              rf_we_q;
  amox_flt_t         flt_out_q;

  amox_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SP_ALIGN_LG2(SP_ALIGN_LG2)
  ) u_decode (
    .feat_en (atomics_en),
    .base_idx(req_base_idx),
    .base_val(req_base_val),
    .sp_val  (req_sp_val),
    .dst_idx (req_dst_idx),
    .acq_flag(req_acquire),
    .rel_flag(req_release),
    .eff_addr(dec_addr),
    .attr    (dec_attr),
    .flt     (dec_flt)
  );

  amox_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .req_flt(|dec_flt),
    .acq    (attr_q.acq),
    .rvalid (mem_rvalid),
    .wack   (mem_wack),
    .state  (state),
    .fin    (fin),
    .cap_en (cap_en)
  );

  amox_datapath #(.MEM_DW(MEM_DW), .HSEL_W(HSEL_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .hsel   (addr_q[HSEL_W:1]),
    .rdata  (mem_rdata),
    .operand(opnd_q),
    .old_hw (old_hw),
    .wdata  (mem_wdata),
    .be     (mem_be)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      opnd_q <= '0;
      dst_q  <= '0;
      attr_q <= '0;
      flt_q  <= '0;
    end else if (accept) begin
      addr_q <= dec_addr[ADDR_W-1:1];
      opnd_q <= req_operand;
      dst_q  <= req_dst_idx;
      attr_q <= dec_attr;
      flt_q  <= dec_flt;
    end
  end

  // completion outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      rf_we_q   <= 1'b0;
      flt_out_q <= '0;
    end else begin
      done_q    <= fin;
      rf_we_q   <= fin && !(|flt_q) && (dst_q != ZR_IDX);
      flt_out_q <= fin ? flt_q : '0;
    end
  end

  assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we     = (state == ST_WRITE);
  assign mem_lock   = mem_req || (state == ST_WACK);
  assign mem_addr   = addr_q[ADDR_W-1:BYTE_LG2];
  assign mem_acq    = attr_q.acq;
  assign mem_rel    = attr_q.rel;
  assign mem_tagchk = attr_q.tagchk;

  assign done        = done_q;
  assign rf_we       = rf_we_q;
  assign rf_idx      = dst_q;
  assign rf_data     = {{(RF_W-16){1'b0}}, old_hw};
  assign flt_illegal = flt_out_q.illegal;
  assign flt_stack   = flt_out_q.stack;
  assign flt_align   = flt_out_q.align;

  a_r8_req_inside_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  a_r8_locked_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !req_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_no_discard_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_idx != ZR_IDX));

  a_r6_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_illegal || flt_stack || flt_align) |-> (done && !rf_we));

  a_r9_acq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_acq && !flt_illegal && !flt_stack && !flt_align) |-> $past(mem_wack));

  a_r7_write_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (|mem_be));

endmodule

// File: tb/tb_amo_xorh_unit.sv
module tb_amo_xorh_unit;

  localparam int CLK_PER = 10;
  localparam int NWORDS  = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        atomics_en;
  logic        req_valid;
  logic        req_ready;
  logic [4:0]  req_base_idx;
  logic [63:0] req_base_val;
  logic [63:0] req_sp_val;
  logic [15:0] req_operand;
  logic [4:0]  req_dst_idx;
  logic        req_acquire;
  logic        req_release;
  logic        mem_req, mem_we, mem_lock;
  logic [61:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_acq, mem_rel, mem_tagchk;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        mem_wack;
  logic        done, rf_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_data;
  logic        flt_illegal, flt_stack, flt_align;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int rd_lat = 1;
  int wr_lat = 1;

  logic [31:0] mem    [NWORDS];
  logic [31:0] shadow [NWORDS];

  amo_xorh_unit dut (
    .clk(clk), .rst_n(rst_n), .atomics_en(atomics_en),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base_idx(req_base_idx), .req_base_val(req_base_val),
    .req_sp_val(req_sp_val), .req_operand(req_operand),
    .req_dst_idx(req_dst_idx), .req_acquire(req_acquire),
    .req_release(req_release),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_acq(mem_acq), .mem_rel(mem_rel), .mem_tagchk(mem_tagchk),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_wack(mem_wack),
    .done(done), .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .flt_illegal(flt_illegal), .flt_stack(flt_stack), .flt_align(flt_align)
  );

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory: read data after rd_lat cycles, write ack after wr_lat cycles
  int rcnt, wcnt;
  logic wpend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      mem_wack   <= 1'b0;
      wpend      <= 1'b0;
      rcnt       <= 0;
      wcnt       <= 0;
      for (int i = 0; i < NWORDS; i++) mem[i] <= (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    end else begin
      mem_rvalid <= 1'b0;
      mem_wack   <= 1'b0;
      if (mem_req && !mem_we && !mem_rvalid) begin
        if (rcnt + 1 >= rd_lat) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[9:0]];
          rcnt       <= 0;
        end else rcnt <= rcnt + 1;
      end
      if (mem_req && mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        wpend <= 1'b1;
        wcnt  <= 0;
      end else if (wpend) begin
        if (wcnt + 1 >= wr_lat) begin
          mem_wack <= 1'b1;
          wpend    <= 1'b0;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit feat, input logic [4:0] bidx, input logic [63:0] bval,
                        input logic [63:0] spv, input logic [15:0] opnd,
                        input logic [4:0] dst, input bit acq, input bit rel,
                        input int rl, input int wl);
    logic [63:0] addr;
    bit e_ill, e_stk, e_al, e_flt, acq_eff, e_we, hsel;
    int widx, t0, cw, ca, cd;
    bit saw_rd, saw_wr, acked, got_done, lock_bad, rdy_bad;
    logic [15:0] old, nw;
    logic [31:0] exp_word;
    addr    = (bidx == 5'd31) ? spv : bval;
    e_ill   = !feat;
    e_stk   = feat && (bidx == 5'd31) && (spv[3:0] != 4'd0);
    e_al    = feat && !e_stk && addr[0];
    e_flt   = e_ill || e_stk || e_al;
    acq_eff = acq && (dst != 5'd31);
    e_we    = !e_flt && (dst != 5'd31);
    widx    = int'(addr[11:2]);
    hsel    = addr[1];
    old     = hsel ? shadow[widx][31:16] : shadow[widx][15:0];
    nw      = old ^ opnd;
    exp_word = shadow[widx];
    if (!e_flt) begin
      if (hsel) exp_word[31:16] = nw; else exp_word[15:0] = nw;
    end
    rd_lat = rl;
    wr_lat = wl;
    cw = -1; ca = -1; cd = -1;
    saw_rd = 0; saw_wr = 0; acked = 0; got_done = 0; lock_bad = 0; rdy_bad = 0;

    @(negedge clk);
    atomics_en = feat; req_base_idx = bidx; req_base_val = bval; req_sp_val = spv;
    req_operand = opnd; req_dst_idx = dst; req_acquire = acq; req_release = rel;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t0 = cyc;
    for (int n = 0; n < 80; n++) begin
      if (mem_req && !mem_we && !saw_rd) begin
        saw_rd = 1;
        chk(mem_acq == acq_eff, "R4", "acquire attribute", mem_acq, acq_eff);
        chk(mem_rel == rel, "R4", "release attribute", mem_rel, rel);
        chk(mem_tagchk == (bidx != 5'd31), "R4", "tag check attribute", mem_tagchk, bidx != 5'd31);
        chk(mem_addr == addr[63:2], "R5", "word address", mem_addr, addr[63:2]);
      end
      if (mem_req && mem_we && !saw_wr) begin
        saw_wr = 1;
        cw = cyc;
        chk(mem_be == (hsel ? 4'hC : 4'h3), "R10", "byte enables", mem_be, hsel ? 4'hC : 4'h3);
      end
      if ((saw_rd || saw_wr) && !acked && !mem_lock) lock_bad = 1;
      if (mem_lock && req_ready) rdy_bad = 1;
      if (mem_wack && !acked) begin acked = 1; ca = cyc; end
      if (done) begin
        got_done = 1;
        cd = cyc;
        chk(rf_we == e_we, e_we ? "R2" : "R3", "register write enable", rf_we, e_we);
        if (e_we) begin
          chk(rf_idx == dst, "R2", "register index", rf_idx, dst);
          chk(rf_data == {16'h0, old}, "R2", "returned value", rf_data, {16'h0, old});
        end
        chk(flt_illegal == e_ill, "R6", "illegal flag", flt_illegal, e_ill);
        chk(flt_stack == e_stk, "R5", "stack fault flag", flt_stack, e_stk);
        chk(flt_align == e_al, "R7", "alignment fault flag", flt_align, e_al);
        break;
      end
      @(negedge clk);
    end
    chk(got_done, "R9", "watchdog: done seen", got_done, 1);
    if (e_flt) begin
      chk(!saw_rd && !saw_wr, "R6", "no memory access on fault", saw_rd || saw_wr, 0);
      chk(cd == t0 + 1, "R9", "fault done cycle", cd, t0 + 1);
    end else begin
      if (acq_eff) chk(cd == ca + 1, "R9", "acquire done cycle", cd, ca + 1);
      else         chk(cd == cw + 1, "R9", "release done cycle", cd, cw + 1);
      chk(!lock_bad, "R8", "lock held through write ack", lock_bad, 0);
      chk(!rdy_bad, "R8", "not ready while locked", rdy_bad, 0);
    end
    // let any pending acknowledge finish before inspecting memory
    while (mem_lock) @(negedge clk);
    @(negedge clk);
    chk(!done, "R9", "done is one cycle", done, 0);
    chk(mem[widx] == exp_word, "R1", "memory word", mem[widx], exp_word);
    shadow[widx] = exp_word;
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run hung, actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) shadow[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    rst_n = 1'b0; atomics_en = 1'b1; req_valid = 1'b0;
    req_base_idx = '0; req_base_val = '0; req_sp_val = '0; req_operand = '0;
    req_dst_idx = '0; req_acquire = 1'b0; req_release = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !mem_lock && !mem_req && !rf_we, "R8", "reset state",
        {req_ready, done, mem_lock, mem_req, rf_we}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R10: low halfword, no ordering
    run_op(1, 5'd4, 64'h0000_0000_0000_0100, 64'h0, 16'hA5A5, 5'd3, 0, 0, 1, 1);
    // R10 R4 R9: high halfword, acquire and release, slow memory
    run_op(1, 5'd7, 64'hFFFF_0000_0000_0102, 64'h0, 16'h0F0F, 5'd9, 1, 1, 3, 4);
    // R1: same word again, other half, reads back previous update
    run_op(1, 5'd7, 64'hFFFF_0000_0000_0100, 64'h0, 16'hFFFF, 5'd1, 0, 1, 2, 2);
    // R3 R4: discard destination drops acquire
    run_op(1, 5'd2, 64'h0000_0000_0000_0206, 64'h0, 16'h1234, 5'd31, 1, 0, 1, 3);
    // R5: stack pointer as base, aligned
    run_op(1, 5'd31, 64'hDEAD_0000_0000_0002, 64'h0000_0000_0000_0330, 16'h8001, 5'd5, 1, 0, 2, 1);
    // R5: stack pointer misaligned
    run_op(1, 5'd31, 64'h0, 64'h0000_0000_0000_0338, 16'h5555, 5'd5, 0, 0, 1, 1);
    // R6: feature off, with an odd address too (illegal wins)
    run_op(0, 5'd3, 64'h0000_0000_0000_0041, 64'h0, 16'h7777, 5'd6, 0, 0, 1, 1);
    // R7: odd halfword address
    run_op(1, 5'd3, 64'h0000_0000_0000_0043, 64'h0, 16'h7777, 5'd6, 1, 0, 1, 1);
    // R2 R9: acquire with long acknowledge
    run_op(1, 5'd8, 64'h0000_0000_0000_0FFE, 64'h0, 16'h0001, 5'd30, 1, 0, 1, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule